// File: doc/BRIEF.md
# Dual Periodic Service Request Timer

This block produces periodic service requests, typically used to trigger DRAM refresh, for two independent pattern sequencers. A single-cycle reference tick input, derived from a free-running reference clock, is first divided by a programmable prescaler that both channels share. Each channel then divides the prescaled tick by its own period value. When a channel's period elapses while that channel is enabled, its request output goes high. The matching sequencer answers by starting its periodic-service routine and pulsing the channel's acknowledge.

Configuration arrives on plain parallel inputs. Each channel has its own period field, enable bit, acknowledge and request, and the two channels do not interact except through the shared prescaled tick. A pending request stays high until it is acknowledged. Further expiries while a request is pending merge into that one request.

Top module: `refresh_req_timer`

## Requirements
- R1: After reset both request outputs are low, and the prescaler and both period counters start from zero.
- R2: The prescaler counts reference ticks, not clock cycles, and produces one prescaled tick per P reference ticks, where P is `presc_cfg`. The encoding 0 means 256.
- R3: With channel c enabled from reset, `svc_req[c]` first rises on the clock edge after the edge that samples reference tick number P*M. M is the channel's 8-bit period field `period_cfg[8c+7:8c]`, and the encoding 0 means 256.
- R4: While channel c stays enabled, its period counter expires again every P*M reference ticks, so after an acknowledge the request rises again one period later.
- R5: Once set, a request stays high until the channel's acknowledge is sampled high. It is then low after that edge, provided no expiry happens on the same edge.
- R6: An expiry while the request is already pending is not counted twice: a single acknowledge clears a request that has seen several expiries.
- R7: When an expiry and an acknowledge for the same channel fall on the same edge, the request remains high.
- R8: While a channel's enable is low, its request is low after each edge, and its period counter is held at zero. After re-enabling, the request is raised by the M-th prescaled tick consumed after the enable returns.
- R9: The channels are independent: each one uses only its own period, enable and acknowledge, and the prescaler keeps running whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| presc_cfg | input | 8 | Shared prescaler divide value (0 means 256) |
| period_cfg | input | 16 | Channel period values, channel c in bits 8c+7:8c (0 means 256) |
| chan_en | input | 2 | Per-channel enable |
| svc_ack | input | 2 | Per-channel service acknowledge |
| svc_req | output | 2 | Per-channel pending service request |

## Verification
Two registers lie on the path from input to request: the prescaled tick is registered, and the request flag is registered. A request therefore shows one edge after the edge that samples the final reference tick of a period. An acknowledge or an enable change shows after the single edge that samples it. The bench numbers every edge from the end of reset and computes each due edge arithmetically from P, M and the tick spacing. It samples on the falling edge that follows each rising edge, and checks both the edge just before a due edge (still low) and the due edge itself (high).

// File: rtl/rrt_pkg.sv
package rrt_pkg;

   // Action applied to a request flag on the next clock edge.
   typedef enum logic [1:0] {
      FLAG_KEEP  = 2'd0,
      FLAG_RAISE = 2'd1,
      FLAG_DROP  = 2'd2
   } flag_op_e;

endpackage

// File: rtl/rrt_divider.sv
// Modulo-N step counter: divides step pulses by div, where div of 0 means 2^W.
module rrt_divider #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] div,
   output logic         wrap
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;
   logic [W-1:0] last;

   // A div of zero wraps to all ones, giving a count of 2^W.
   assign last = div - ONE;
   // Comparing with >= keeps the counter bounded if div shrinks mid-count.
   assign wrap = step && !clr && (cnt_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= wrap ? '0 : cnt_q + ONE;
      end
   end

endmodule

// File: rtl/rrt_prescaler.sv
// Shared prescaler with a registered output pulse.
module rrt_prescaler #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ref_tick,
   input  logic [W-1:0] div,
   output logic         tick_o
);

   logic wrap;

   rrt_divider #(.W(W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (1'b0),
      .step  (ref_tick),
      .div   (div),
      .wrap  (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_o <= 1'b0;
      else        tick_o <= wrap;
   end

endmodule

// File: rtl/rrt_req_flag.sv
// Sticky request flag: disable beats expiry, and expiry beats acknowledge.
module rrt_req_flag
   import rrt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic set,
   input  logic ack,
   output logic req
);

   flag_op_e op;

   always_comb begin
      if (!en)      op = FLAG_DROP;
      else if (set) op = FLAG_RAISE;
      else if (ack) op = FLAG_DROP;
      else          op = FLAG_KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
      end else begin
         unique case (op)
            FLAG_RAISE: req <= 1'b1;
            FLAG_DROP:  req <= 1'b0;
            default:    req <= req;
         endcase
      end
   end

endmodule

// File: rtl/refresh_req_timer.sv
module refresh_req_timer #(
   parameter int NCH   = 2,
   parameter int CFG_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ref_tick,
   input  logic [CFG_W-1:0]     presc_cfg,
   input  logic [NCH*CFG_W-1:0] period_cfg,
   input  logic [NCH-1:0]       chan_en,
   input  logic [NCH-1:0]       svc_ack,
   output logic [NCH-1:0]       svc_req
);

   localparam int CFG_BUS_W = NCH * CFG_W;

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("refresh_req_timer: NCH must lie in 1..8");
   end
   if (CFG_W < 2 || CFG_W > 16) begin : g_bad_cfg_w
      $error("refresh_req_timer: CFG_W must lie in 2..16");
   end
   if (CFG_BUS_W != $bits(period_cfg)) begin : g_bad_bus
      $error("refresh_req_timer: period bus width mismatch");
   end

   logic presc_tick;

   rrt_prescaler #(.W(CFG_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .div      (presc_cfg),
      .tick_o   (presc_tick)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic expire;

      rrt_divider #(.W(CFG_W)) u_period (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (!chan_en[c]),
         .step  (presc_tick),
         .div   (period_cfg[c*CFG_W +: CFG_W]),
         .wrap  (expire)
      );

      rrt_req_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (chan_en[c]),
         .set   (expire),
         .ack   (svc_ack[c]),
         .req   (svc_req[c])
      );
   end

endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ref_tick,
   input logic           presc_tick,
   input logic [NCH-1:0] chan_en,
   input logic [NCH-1:0] svc_ack,
   input logic [NCH-1:0] svc_req
);

   // A prescaled tick always follows a sampled reference tick.
   p_presc_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      presc_tick |-> $past(ref_tick));

   for (genvar c = 0; c < NCH; c++) begin : g_chk
      // A request rises only on the edge that consumes a prescaled tick.
      p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(svc_req[c]) |-> $past(presc_tick));

      // A pending request with no acknowledge stays pending.
      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (svc_req[c] && !svc_ack[c] && chan_en[c]) |=> svc_req[c]);

      // An acknowledge with no prescaled tick on that edge clears the request.
      p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (svc_ack[c] && chan_en[c] && !presc_tick) |=> !svc_req[c]);

      // A disabled channel shows no request after the edge.
      p_off_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_en[c] |=> !svc_req[c]);
   end

endmodule

bind refresh_req_timer rrt_checker #(.NCH(NCH)) u_rrt_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_tick   (ref_tick),
   .presc_tick (presc_tick),
   .chan_en    (chan_en),
   .svc_ack    (svc_ack),
   .svc_req    (svc_req)
);

// File: tb/tb_refresh_req_timer.sv
`timescale 1ns/1ps
module tb_refresh_req_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic [7:0]  presc_cfg = '0;
   logic [15:0] period_cfg = '0;
   logic [1:0]  chan_en = '0;
   logic [1:0]  svc_ack = '0;
   logic [1:0]  svc_req;

   int e = 0;
   int n_chk = 0;
   int n_fail = 0;
   bit sparse = 1'b0;

   always #4 clk = ~clk;

   refresh_req_timer #(.NCH(2), .CFG_W(8)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick   (ref_tick),
      .presc_cfg  (presc_cfg),
      .period_cfg (period_cfg),
      .chan_en    (chan_en),
      .svc_ack    (svc_ack),
      .svc_req    (svc_req)
   );

   task automatic chk(input string rq, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s at edge %0d: actual %b expected %b", rq, what, e, act, exp);
      end
   endtask

   // Advance n rising edges. Each pass drives ref_tick for the coming edge and ends on a falling edge.
   task automatic adv(input int n);
      for (int i = 0; i < n; i++) begin
         ref_tick = sparse ? ((e + 1) % 3 == 0) : 1'b1;
         @(negedge clk);
         e++;
      end
   endtask

   task automatic ack(input int c);
      svc_ack[c] = 1'b1;
      adv(1);
      svc_ack[c] = 1'b0;
   endtask

   task automatic start(input int p, input int m0, input int m1, input logic [1:0] en, input bit sp);
      rst_n = 1'b0;
      ref_tick = 1'b0;
      svc_ack = '0;
      presc_cfg = 8'(p);
      period_cfg = {8'(m1), 8'(m0)};
      chan_en = en;
      sparse = sp;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      e = 0;
      chk("R1", "ch0 after reset", svc_req[0], 1'b0);
      chk("R1", "ch1 after reset", svc_req[1], 1'b0);
   endtask

   // Check both channels on each edge up to 'upto'. A request is expected from its due edge on.
   task automatic watch(input string rq, input int d0, input int d1, input int upto);
      while (e < upto) begin
         adv(1);
         chk(rq, "ch0", svc_req[0], e >= d0);
         chk(rq, "ch1", svc_req[1], e >= d1);
      end
   endtask

   initial begin
      // R3: sweep small prescale and period values, both channels enabled
      for (int p = 1; p <= 4; p++) begin
         for (int m0 = 1; m0 <= 4; m0++) begin
            int m1;
            int mx;
            m1 = m0 % 4 + 1;
            mx = (m0 > m1) ? m0 : m1;
            start(p, m0, m1, 2'b11, 1'b0);
            watch("R3", p * m0 + 1, p * m1 + 1, p * mx + 2);
         end
      end

      // R2: prescale encoding 0 means 256
      start(0, 1, 2, 2'b11, 1'b0);
      watch("R2", 257, 513, 513);

      // R3: period encoding 0 means 256
      start(1, 0, 3, 2'b11, 1'b0);
      watch("R3", 257, 4, 257);

      // R2: the prescaler counts reference ticks, which arrive here on every third edge
      start(2, 2, 3, 2'b11, 1'b1);
      watch("R2", 13, 19, 20);

      // R4 R5 R6 R7: handshake, P=3, M0=2 (6 ticks), M1=4 (12 ticks)
      start(3, 2, 4, 2'b11, 1'b0);
      watch("R5", 7, 13, 7);
      ack(0);
      chk("R5", "ch0 cleared by ack", svc_req[0], 1'b0);
      adv(4);
      chk("R4", "ch0 low before next period", svc_req[0], 1'b0);
      adv(1);
      chk("R4", "ch0 second period", svc_req[0], 1'b1);
      chk("R3", "ch1 first period", svc_req[1], 1'b1);
      ack(0);
      chk("R5", "ch0 cleared again", svc_req[0], 1'b0);
      adv(4);
      chk("R5", "ch0 low while idle", svc_req[0], 1'b0);
      svc_ack[0] = 1'b1;
      adv(1);
      svc_ack[0] = 1'b0;
      chk("R7", "ch0 expiry beats ack", svc_req[0], 1'b1);
      adv(12);
      chk("R6", "ch0 pending across expiries", svc_req[0], 1'b1);
      ack(0);
      chk("R6", "ch0 single ack clears merged", svc_req[0], 1'b0);
      adv(4);
      chk("R6", "ch0 no second request", svc_req[0], 1'b0);
      adv(1);
      chk("R4", "ch0 next period", svc_req[0], 1'b1);
      ack(1);
      chk("R6", "ch1 single ack clears merged", svc_req[1], 1'b0);
      chk("R9", "ch0 unaffected by ch1 ack", svc_req[0], 1'b1);
      adv(2);
      chk("R6", "ch1 stays low", svc_req[1], 1'b0);
      adv(9);
      chk("R4", "ch1 next period", svc_req[1], 1'b1);

      // R8: dropping the enable clears the request and restarts the count, P=2, M0=3, M1=5
      start(2, 3, 5, 2'b11, 1'b0);
      adv(7);
      chk("R3", "ch0 first period", svc_req[0], 1'b1);
      adv(1);
      chan_en[0] = 1'b0;
      adv(1);
      chan_en[0] = 1'b1;
      chk("R8", "ch0 cleared by disable", svc_req[0], 1'b0);
      adv(1);
      chk("R9", "ch1 before due", svc_req[1], 1'b0);
      adv(1);
      chk("R9", "ch1 due regardless of ch0", svc_req[1], 1'b1);
      adv(3);
      chk("R8", "ch0 restarted count low", svc_req[0], 1'b0);
      adv(1);
      chk("R8", "ch0 restarted count due", svc_req[0], 1'b1);

      // R8 R9: ch0 held disabled, ch1 running with M1=1
      start(1, 2, 1, 2'b10, 1'b0);
      for (int i = 0; i < 20; i++) begin
         adv(1);
         chk("R8", "ch0 disabled", svc_req[0], 1'b0);
         chk("R9", "ch1 alone", svc_req[1], e >= 2);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule